// File: doc/BRIEF.md
# One-Time-Programmable Word Store with Mode Decoder

This block models a word-organised memory that can be programmed once and cleared only by a bulk erase. It sits on a system clock. On every rising edge it samples an address, three active-low controls (chip select `ceN`, output gate `oeN`, program strobe `pgmN`) and two level flags. One flag says the programming supply is present. The other says a high voltage is applied to the identification select line. From these it decodes six operating modes: standby, read, output off, program, program verify and program inhibit.

Outputs are registered. The word that a read selects appears, together with its tristate enable `rdDrive`, one clock after the inputs that select it are sampled. A program operation can only clear bits: the stored word becomes the old word ANDed with `wrData`. Bits return to 1 only through the erase input, which sweeps the whole array one word per clock. An identification override replaces the array word with a fixed code. Address bit 0 chooses between the maker code and the part code.

Top module: `otp_mode_array`

## Requirements
- R1: While `rstN` is low and after it is released, `rdDrive` and `eraseBusy` are 0. `rdData` is all zeros in every cycle where `rdDrive` is 0.
- R2: When `eraseBusy`=0, `ceN`=0, `oeN`=0, `vppHigh`=0 and `idHv`=0 are sampled at a rising edge, then after that edge `rdDrive`=1 and `rdData` holds the word stored at `addr`.
- R3: A sampled `ceN`=1 gives `rdDrive`=0 after that edge, whatever the value of `oeN`.
- R4: A sampled `ceN`=0 with `oeN`=1 gives `rdDrive`=0 after that edge. No write occurs unless the R5 conditions hold.
- R5: A word is written only at an edge where `vppHigh`=1, `ceN`=0 and `oeN`=1 are sampled and `pgmN` is sampled 0 after being sampled 1 at the previous edge. The same strobe pattern with `vppHigh`=0 writes nothing.
- R6: Holding `pgmN` low over several edges writes only once. Data presented on the later edges has no effect.
- R7: A write stores the old word AND `wrData`. A 1 in `wrData` never sets a cleared bit.
- R8: A sampled `vppHigh`=1, `ceN`=0, `oeN`=0, `pgmN`=1 drives the stored word on the next cycle. The same pattern with `pgmN`=0 drives nothing.
- R9: With `vppHigh`=1 and `ceN`=1, a `pgmN` pulse writes nothing and `rdDrive` stays 0.
- R10: If `eraseReq` is sampled 1 while not busy, `eraseBusy` is 1 for exactly DEPTH cycles. Afterwards every word reads 16'hFFFF. While busy, `rdDrive` is 0, program pulses are ignored and further erase requests are ignored.
- R11: In read or verify conditions with `idHv`=1, `rdData` is 16'h008F when `addr[0]`=0 and 16'h00D6 when `addr[0]`=1. All other address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of control and output registers (array contents kept) |
| addr | input | ADDR_W | Word address |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output gate |
| pgmN | input | 1 | Active-low program strobe; its falling edge writes |
| vppHigh | input | 1 | Programming supply present |
| idHv | input | 1 | High voltage on the identification select line |
| wrData | input | DATA_W | Word to program (AND-merged) |
| eraseReq | input | 1 | Start a full-array erase to all ones |
| rdData | output | DATA_W | Registered read word, zero when not driving |
| rdDrive | output | 1 | Enable for the external tristate driver |
| eraseBusy | output | 1 | High while the erase sweep runs |

## Verification
On every cycle the assertions check four things. Deselect, output-off and a busy erase never drive. A clean read condition always drives. An identification request returns the code chosen by address bit 0. The erase sweep never lasts longer than the array depth. The bench model covers what a single-cycle property cannot express well: that each strobe writes only once, that writes AND-merge, that writes are refused without the programming supply or under inhibit, and that every word reads back as ones after the sweep.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] MFG_CODE = 8'h8F;
  localparam logic [7:0] DEV_CODE = 8'hD6;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_OUTOFF,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_INHIBIT
  } otpMode_e;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic wrEn;
    logic drive;
    logic idSel;
    logic eraseStep;
  } otpStrobe_t;
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              idHv,
  input  logic              eraseReq,
  output otpStrobe_t        strobe,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  otpMode_e mode;
  logic     pgmPrev;
  logic     pgmFall;

  always_comb begin
    if (ceN)           mode = vppHigh ? MODE_INHIBIT : MODE_STANDBY;
    else if (!vppHigh) mode = oeN ? MODE_OUTOFF : MODE_READ;
    else if (oeN)      mode = pgmN ? MODE_OUTOFF : MODE_PROGRAM;
    else               mode = pgmN ? MODE_VERIFY : MODE_OUTOFF;
  end

  assign pgmFall = pgmPrev & ~pgmN;

  always_comb begin
    strobe.wrEn      = !busy && (mode == MODE_PROGRAM) && pgmFall;
    strobe.drive     = !busy && ((mode == MODE_READ) || (mode == MODE_VERIFY));
    strobe.idSel     = idHv;
    strobe.eraseStep = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmPrev   <= 1'b1;
      busy      <= 1'b0;
      eraseAddr <= '0;
    end else begin
      pgmPrev <= pgmN;
      if (busy) begin
        if (eraseAddr == LAST_ADDR) begin
          busy      <= 1'b0;
          eraseAddr <= '0;
        end else begin
          eraseAddr <= eraseAddr + 1'b1;
        end
      end else if (eraseReq) begin
        busy      <= 1'b1;
        eraseAddr <= '0;
      end
    end
  end
endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] idWord;
  logic [DATA_W-1:0] nextData;

  assign idWord = {{PAD_W{1'b0}}, (addr[0] ? DEV_CODE : MFG_CODE)};

  always_comb begin
    if (!strobe.drive)     nextData = '0;
    else if (strobe.idSel) nextData = idWord;
    else                   nextData = cells[addr];
  end

  // Array holds its contents through reset; only the sweep sets ones
  always_ff @(posedge clk) begin
    if (strobe.eraseStep)  cells[eraseAddr] <= '1;
    else if (strobe.wrEn)  cells[addr] <= cells[addr] & wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdDrive <= 1'b0;
    end else begin
      rdData  <= nextData;
      rdDrive <= strobe.drive;
    end
  end
endmodule

// File: rtl/otp_mode_array.sv
module otp_mode_array
  import otp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              pgmN,
  input  logic              vppHigh,
  input  logic              idHv,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eraseReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              eraseBusy
);
  otpStrobe_t        strobe;
  logic [ADDR_W-1:0] eraseAddr;

  otp_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHigh(vppHigh), .idHv(idHv), .eraseReq(eraseReq),
    .strobe(strobe), .eraseAddr(eraseAddr), .busy(eraseBusy)
  );

  otp_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .eraseAddr(eraseAddr), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/otp_mode_array_chk.sv
module otp_mode_array_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic              oeN,
  input logic              pgmN,
  input logic              vppHigh,
  input logic              idHv,
  input logic              eraseReq,
  input logic [DATA_W-1:0] rdData,
  input logic              rdDrive,
  input logic              eraseBusy
);
  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyRun <= 0;
    else if (eraseBusy) busyRun <= busyRun + 1;
    else                busyRun <= 0;
  end

  logic readCond;
  assign readCond = !eraseBusy && !ceN && !oeN && !(vppHigh && !pgmN);

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdDrive |-> (rdData == '0));

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseBusy && !ceN && !oeN && !vppHigh) |=> rdDrive);

  p_standby_r3: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !rdDrive);

  p_out_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |=> !rdDrive);

  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (vppHigh && ceN) |=> !rdDrive);

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |=> !rdDrive);

  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> (busyRun < DEPTH));

  p_id_mfg_r11: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && idHv && !addr[0]) |=> (rdData == DATA_W'(16'h008F)));

  p_id_dev_r11: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && idHv && addr[0]) |=> (rdData == DATA_W'(16'h00D6)));
endmodule

bind otp_mode_array otp_mode_array_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
  .vppHigh(vppHigh), .idHv(idHv), .eraseReq(eraseReq),
  .rdData(rdData), .rdDrive(rdDrive), .eraseBusy(eraseBusy)
);

// File: tb/otp_mode_array_bench.sv
module otp_mode_array_bench;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          ceN, oeN, pgmN, vppHigh, idHv, eraseReq;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic          rdDrive, eraseBusy;

  int    nRun  = 0;
  int    nFail = 0;
  string curReq;

  // Reference model state
  logic [DW-1:0] expMem [DEPTH];
  bit            expBusy  = 0;
  int            expCnt   = 0;
  bit            expPrev  = 1;
  bit            expDrive = 0;
  logic [DW-1:0] expData  = '0;

  always #10 clk = ~clk;

  otp_mode_array #(.DEPTH(DEPTH), .DATA_W(DW)) u_otp_mode_array (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .pgmN(pgmN),
    .vppHigh(vppHigh), .idHv(idHv), .wrData(wrData), .eraseReq(eraseReq),
    .rdData(rdData), .rdDrive(rdDrive), .eraseBusy(eraseBusy)
  );

  task automatic modelEdge();
    bit fall;
    if (!rstN) begin
      expBusy = 0; expCnt = 0; expPrev = 1; expDrive = 0; expData = '0;
      return;
    end
    fall    = expPrev && !pgmN;
    expPrev = pgmN;
    if (expBusy) begin
      expDrive = 0;
      expData  = '0;
      expMem[expCnt] = 16'hFFFF;
      if (expCnt == DEPTH - 1) begin expBusy = 0; expCnt = 0; end
      else expCnt++;
    end else begin
      expDrive = !ceN && !oeN && !(vppHigh && !pgmN);
      if (!expDrive)  expData = '0;
      else if (idHv)  expData = addr[0] ? 16'h00D6 : 16'h008F;
      else            expData = expMem[int'(addr)];
      if (vppHigh && !ceN && oeN && fall)
        expMem[int'(addr)] = expMem[int'(addr)] & wrData;
      if (eraseReq) begin expBusy = 1; expCnt = 0; end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    nRun++;
    if (rdDrive !== expDrive || rdData !== expData || eraseBusy !== expBusy) begin
      nFail++;
      $display("FAIL %s: drive/data/busy = %0b/%h/%0b expected %0b/%h/%0b",
               curReq, rdDrive, rdData, eraseBusy, expDrive, expData, expBusy);
    end
  endtask

  task automatic idle();
    ceN = 1; oeN = 1; pgmN = 1; vppHigh = 0; idHv = 0; eraseReq = 0;
    wrData = '0; addr = '0;
  endtask

  task automatic readAt(input int a);
    ceN = 1'b0; oeN = 1'b0; vppHigh = 1'b0; pgmN = 1'b1; addr = AW'(a);
    tick();
  endtask

  task automatic progPulse(input int a, input logic [DW-1:0] d, input logic vpp,
                           input logic ce);
    ceN = ce; oeN = 1'b1; vppHigh = vpp; addr = AW'(a); wrData = d;
    pgmN = 1'b1; tick();
    pgmN = 1'b0; tick();
    pgmN = 1'b1; tick();
  endtask

  task automatic runErase();
    eraseReq = 1'b1; tick();
    eraseReq = 1'b0;
    for (int i = 0; i < DEPTH + 1; i++) tick();
  endtask

  initial begin
    idle();
    rstN = 1'b0;
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    tick();

    curReq = "R10";
    runErase();
    curReq = "R2";
    for (int a = 0; a < DEPTH; a++) readAt(a);

    curReq = "R3";
    ceN = 1; oeN = 0; tick();
    ceN = 1; oeN = 1; tick();
    curReq = "R4";
    ceN = 0; oeN = 1; vppHigh = 0; tick();

    curReq = "R5";
    progPulse(3, 16'hA5A5, 1'b1, 1'b0);
    curReq = "R8";
    vppHigh = 1; ceN = 0; oeN = 0; pgmN = 1; addr = 3; tick(); tick();
    pgmN = 0; tick();
    pgmN = 1; tick();

    curReq = "R6";
    ceN = 0; oeN = 1; vppHigh = 1; addr = 4; wrData = 16'hF0F0; pgmN = 1; tick();
    pgmN = 0; tick();
    wrData = 16'h0F0F; tick(); tick(); tick();
    pgmN = 1; tick();
    readAt(4);

    curReq = "R7";
    progPulse(3, 16'hFFF0, 1'b1, 1'b0);
    progPulse(3, 16'hFFFF, 1'b1, 1'b0);
    readAt(3);

    curReq = "R5";
    progPulse(5, 16'h0000, 1'b0, 1'b0);
    readAt(5);

    curReq = "R9";
    progPulse(6, 16'h0000, 1'b1, 1'b1);
    ceN = 1; oeN = 0; pgmN = 0; tick();
    readAt(6);

    curReq = "R11";
    idHv = 1;
    readAt(0); readAt(1); readAt(6); readAt(DEPTH - 1);
    ceN = 1; tick();
    ceN = 0; oeN = 0; vppHigh = 1; pgmN = 1; addr = 2; tick();
    idHv = 0;

    curReq = "R10";
    progPulse(7, 16'h1234, 1'b1, 1'b0);
    readAt(7);
    eraseReq = 1; tick();
    eraseReq = 0;
    readAt(7); readAt(3);
    eraseReq = 1; tick();
    eraseReq = 0;
    progPulse(8, 16'h0000, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) readAt(i);
    for (int a = 0; a < DEPTH; a++) readAt(a);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule